// File: doc/BRIEF.md
# Multi-Mode Fracturable Logic Element

This block is one programmable logic cell of the kind tiled across a reconfigurable fabric. It holds a 16-bit truth table and two flip-flops. The two flip-flops are the upper one and the lower one. A 2-bit mode field sets how these resources are used, and there are three modes:

- **Single 4-input function.** The whole table is addressed by four inputs, and its result is registered in the upper flip-flop.
- **Split table.** The table splits into two 8-entry halves that share the three low inputs. Each half feeds its own flip-flop, so a carry and a sum, for example, come from one cell.
- **Shift register.** The two flip-flops are chained over a private path as a 2-bit shift register.

Each data output has a bypass bit. The bit selects the combinational table value or the registered value.

The cell is programmed through a parallel configuration word. The word is captured on a clock edge while the configuration enable is high. During configuration the flip-flops keep their state. Outside configuration the stored word stays constant, and the cell behaves as the mapped logic.

Top module: `mle_logic_element`

## Requirements
- R1: `cfg_word` is captured only on a rising edge where `cfg_en` is 1. The stored configuration takes effect from that edge on. The word is laid out as follows:
  - bits [15:0]: truth table
  - bits [17:16]: mode
  - bit 18: bypass of `out_hi`
  - bit 19: bypass of `out_lo`
  - A bypass bit of 1 selects the combinational value.
- R2: In mode 00 with the upper bypass bit set, `out_hi` equals table bit `lut_in[3:0]` in the same cycle.
- R3: In mode 00 with the upper bypass bit clear, `out_hi` shows the table bit addressed at the previous rising edge. In mode 00, `out_lo` is always 0.
- R4: In mode 01, the upper result is table bit {1,`lut_in[2:0]`} and the lower result is table bit {0,`lut_in[2:0]``}`. `lut_in[3]` has no effect. With both bypass bits set, these results appear on `out_hi` and `out_lo` in the same cycle.
- R5: In mode 01 with bypass bits clear, `out_hi` and `out_lo` each show their half's result as sampled at the previous rising edge.
- R6: In mode 10, each rising edge performs two loads:
  - the upper flip-flop loads `shift_in`;
  - the lower flip-flop loads the old upper value.

  `out_hi` shows the upper flip-flop and `out_lo` shows the lower flip-flop, whatever the bypass bits are. `shift_out` shows the lower flip-flop.
- R7: Outside mode 10, `shift_out` is 0.
- R8: A rising edge with `rst` high has two effects:
  - both flip-flops clear to 0;
  - the stored configuration clears to all zeros, which is mode 00, an empty table and both bypass bits clear.
- R9: On an edge where `cfg_en` is 1, both flip-flops keep their value.
- R10: Mode code 11 behaves exactly as mode 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for flip-flops and configuration store |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration capture enable |
| cfg_word | input | 20 | Configuration word: table, mode, bypass bits |
| lut_in | input | 4 | Table address inputs |
| shift_in | input | 1 | Serial input for shift-register mode |
| out_hi | output | 1 | Upper output (registered or combinational) |
| out_lo | output | 1 | Lower output (registered or combinational) |
| shift_out | output | 1 | Serial output, lower flip-flop in shift mode |

## Verification
The outputs are due at different times:
- A bypassed output follows `lut_in` with no clock edge, so the bench checks it one time unit after changing the address, within the same low clock phase.
- A registered output, and each stage of the shift chain, changes one rising edge after its input is sampled. The bench therefore drives at a falling edge and checks at the next falling edge. Before that edge, it also confirms that a new address has not yet reached the registered output.
- A configuration word takes effect only after the capture edge. The bench therefore changes the word with the enable low and checks that the old mapping persists for the next cycle.

// File: rtl/mle_pkg.sv
package mle_pkg;

    localparam int LUT_K   = 4;
    localparam int TBL_W   = 1 << LUT_K;
    localparam int CFG_W   = TBL_W + 4;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_SPLIT = 2'b01,
        MODE_CHAIN = 2'b10,
        MODE_RSVD  = 2'b11
    } le_mode_e;

    typedef struct packed {
        logic             byp_lo;
        logic             byp_hi;
        le_mode_e         mode;
        logic [TBL_W-1:0] table_bits;
    } le_cfg_t;

    typedef struct packed {
        logic full;
        logic upper;
        logic lower;
    } lut_res_t;

    // Reserved code folds onto the single-function mode.
    function automatic le_mode_e norm_mode(input le_mode_e m);
        return (m == MODE_RSVD) ? MODE_FULL : m;
    endfunction

endpackage

// File: rtl/mle_cfg_store.sv
module mle_cfg_store
    import mle_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_en,
    input  le_cfg_t  cfg_in,
    output le_cfg_t  cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_en)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/mle_frac_lut.sv
module mle_frac_lut
    import mle_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      sel,
    output lut_res_t          res
);
    localparam int HALF = 1 << (K - 1);

    logic [HALF-1:0] upper_half;
    logic [HALF-1:0] lower_half;

    assign upper_half = table_bits[2*HALF-1:HALF];
    assign lower_half = table_bits[HALF-1:0];

    always_comb begin
        res.full  = table_bits[sel];
        res.upper = upper_half[sel[K-2:0]];
        res.lower = lower_half[sel[K-2:0]];
    end
endmodule

// File: rtl/mle_ff_pair.sv
module mle_ff_pair
    import mle_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  le_mode_e mode,
    input  logic     d_hi,
    input  logic     d_lo,
    input  logic     sin,
    output logic     q_hi,
    output logic     q_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_hi <= 1'b0;
            q_lo <= 1'b0;
        end else if (!hold) begin
            unique case (mode)
                MODE_CHAIN: begin
                    q_hi <= sin;
                    q_lo <= q_hi;
                end
                MODE_SPLIT: begin
                    q_hi <= d_hi;
                    q_lo <= d_lo;
                end
                default: begin
                    q_hi <= d_hi;
                end
            endcase
        end
    end

    assert_chain_load_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAIN && !hold) |=> (q_hi == $past(sin)));

    assert_chain_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAIN && !hold) |=> (q_lo == $past(q_hi)));

    assert_hold_cfg_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(q_hi) && $stable(q_lo)));

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;
    always @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_clear_R8: assert (q_hi == 1'b0 && q_lo == 1'b0);
        end
    end
endmodule

// File: rtl/mle_logic_element.sv
module mle_logic_element
    import mle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [LUT_K-1:0] lut_in,
    input  logic             shift_in,
    output logic             out_hi,
    output logic             out_lo,
    output logic             shift_out
);
    le_cfg_t  cfg_q;
    le_mode_e mode_eff;
    lut_res_t lres;
    logic     d_hi, d_lo;
    logic     q_hi, q_lo;

    mle_cfg_store u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .cfg_in (le_cfg_t'(cfg_word)),
        .cfg_q  (cfg_q)
    );

    assign mode_eff = norm_mode(cfg_q.mode);

    mle_frac_lut #(.K(LUT_K)) u_lut (
        .table_bits (cfg_q.table_bits),
        .sel        (lut_in),
        .res        (lres)
    );

    always_comb begin
        d_hi = (mode_eff == MODE_SPLIT) ? lres.upper : lres.full;
        d_lo = lres.lower;
    end

    mle_ff_pair u_ff (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg_en),
        .mode (mode_eff),
        .d_hi (d_hi),
        .d_lo (d_lo),
        .sin  (shift_in),
        .q_hi (q_hi),
        .q_lo (q_lo)
    );

    always_comb begin
        out_hi    = 1'b0;
        out_lo    = 1'b0;
        shift_out = 1'b0;
        unique case (mode_eff)
            MODE_CHAIN: begin
                out_hi    = q_hi;
                out_lo    = q_lo;
                shift_out = q_lo;
            end
            MODE_SPLIT: begin
                out_hi = cfg_q.byp_hi ? lres.upper : q_hi;
                out_lo = cfg_q.byp_lo ? lres.lower : q_lo;
            end
            default: begin
                out_hi = cfg_q.byp_hi ? lres.full : q_hi;
            end
        endcase
    end

    assert_full_reg_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == MODE_FULL && !cfg_en) |=> (q_hi == $past(lres.full)));

    assert_split_reg_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == MODE_SPLIT && !cfg_en) |=> (q_lo == $past(lres.lower)));
endmodule

// File: tb/mle_logic_element_test.sv
module mle_logic_element_test;
    import mle_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_en = 1'b0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic [LUT_K-1:0] lut_in = '0;
    logic             shift_in = 1'b0;
    logic             out_hi, out_lo, shift_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mle_logic_element uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cfg_word  (cfg_word),
        .lut_in    (lut_in),
        .shift_in  (shift_in),
        .out_hi    (out_hi),
        .out_lo    (out_lo),
        .shift_out (shift_out)
    );

    // Vector: [33:14] cfg, [13:10] lut_in, [9] out_hi, [8] out_lo, [7:0] requirement number
    localparam int NV = 9;
    localparam logic [33:0] VEC [NV] = '{
        {4'b0100, 16'h6996, 4'b0111, 1'b1, 1'b0, 8'd2},   // R2 parity, odd
        {4'b0100, 16'h6996, 4'b1111, 1'b0, 1'b0, 8'd2},   // R2 parity, even
        {4'b1100, 16'h6996, 4'b0001, 1'b1, 1'b0, 8'd2},   // R2 lower bypass irrelevant
        {4'b1101, 16'hE896, 4'b0011, 1'b1, 1'b0, 8'd4},   // R4 carry 1 sum 0
        {4'b1101, 16'hE896, 4'b0001, 1'b0, 1'b1, 8'd4},   // R4 carry 0 sum 1
        {4'b1101, 16'hE896, 4'b1110, 1'b1, 1'b0, 8'd4},   // R4 bit3 ignored
        {4'b1101, 16'hE896, 4'b0111, 1'b1, 1'b1, 8'd4},   // R4 both 1
        {4'b0111, 16'h6996, 4'b0111, 1'b1, 1'b0, 8'd10},  // R10 reserved as full
        {4'b0111, 16'h6996, 4'b1000, 1'b1, 1'b0, 8'd10}   // R10 reserved, high half
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [CFG_W-1:0] w);
        cfg_word = w;
        cfg_en   = 1'b1;
        tick();
        cfg_en   = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst = 1'b0;
        // R8 reset state
        chk("R8", "out_hi after reset", out_hi, 1'b0);
        chk("R8", "out_lo after reset", out_lo, 1'b0);
        chk("R7", "shift_out after reset", shift_out, 1'b0);

        // Vector walk: combinational results
        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            load_cfg(v[33:14]);
            lut_in = v[13:10];
            #1;
            checks++;
            if (out_hi !== v[9] || out_lo !== v[8]) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%b%b expected=%b%b",
                         v[7:0], i, out_hi, out_lo, v[9], v[8]);
            end
        end

        // R3 registered full mode
        load_cfg({4'b0000, 16'h6996});
        lut_in = 4'b0111;
        tick();
        chk("R3", "registered hi", out_hi, 1'b1);
        chk("R3", "lo is zero", out_lo, 1'b0);
        lut_in = 4'b1111;
        #1;
        chk("R3", "no change before edge", out_hi, 1'b1);
        tick();
        chk("R3", "registered hi next", out_hi, 1'b0);

        // R1 word without enable is not captured
        cfg_word = {4'b0100, 16'h0000};
        lut_in   = 4'b0111;
        tick();
        chk("R1", "old mapping kept", out_hi, 1'b1);

        // R5 registered split mode
        load_cfg({4'b0001, 16'hE896});
        lut_in = 4'b0011;
        tick();
        chk("R5", "carry reg", out_hi, 1'b1);
        chk("R5", "sum reg", out_lo, 1'b0);
        lut_in = 4'b0001;
        #1;
        chk("R5", "carry before edge", out_hi, 1'b1);
        tick();
        chk("R5", "carry reg 2", out_hi, 1'b0);
        chk("R5", "sum reg 2", out_lo, 1'b1);

        // R6 shift chain, bypass bits set and ignored
        rst = 1'b1;
        tick();
        rst = 1'b0;
        load_cfg({4'b1110, 16'hFFFF});
        chk("R9", "hold during load", out_hi, 1'b0);
        begin
            logic [3:0] pat;
            logic       ph, pl;
            pat = 4'b1101;
            ph = 1'b0;
            pl = 1'b0;
            for (int k = 0; k < 4; k++) begin
                shift_in = pat[k];
                tick();
                pl = ph;
                ph = pat[k];
                chk("R6", "upper stage", out_hi, ph);
                chk("R6", "lower stage", out_lo, pl);
                chk("R6", "shift_out", shift_out, pl);
            end
        end

        // R9 hold with cfg_en high
        cfg_word = {4'b1110, 16'hFFFF};
        cfg_en   = 1'b1;
        shift_in = 1'b0;
        tick();
        tick();
        cfg_en = 1'b0;
        chk("R9", "upper held", out_hi, 1'b1);
        chk("R9", "lower held", out_lo, 1'b1);

        // R7 shift_out low outside chain mode (lower ff still 1)
        load_cfg({4'b0001, 16'h0000});
        chk("R7", "lower visible", out_lo, 1'b1);
        chk("R7", "shift_out zero", shift_out, 1'b0);

        // R8 reset mid-run clears both flops and configuration
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R8", "config cleared, hi", out_hi, 1'b0);
        load_cfg({4'b0001, 16'h0000});
        chk("R8", "lower cleared", out_lo, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule